// File: doc/BRIEF.md
# Serial Link Request Receiver

This block sits on the physical-layer side of a PHY/link interface. It watches the single serial request line that the link layer drives and turns each serial request into decoded, parallel form. The line is sampled on every rising edge of the interface clock, which runs at twice the 24.576 MHz base rate (49.152 MHz). While the line is low the receiver stays idle. A high sample is a start bit. The next three samples carry a type code, most significant bit first. That code selects the frame length and the meaning of the bits that follow.

A bus request (types 000 to 011) ends after a 3-bit field. A register read (type 100) carries a 4-bit address. A register write (type 101) carries a 4-bit address and then 8 data bits. Every frame closes with a stop bit that must be low. A valid frame raises exactly one strobe for one cycle, and the payload fields stay on the outputs until the next accepted request. A stop bit that is high raises an error pulse and the request is discarded. Any type code other than 000 to 101 is dropped silently. Arbitration, the register file and the control/data bus lie outside the block.

Top module: `lreq_rx`

## Requirements
- R1: While idle, a low line sample raises no strobe and no error. A high sample is taken as the start bit (bit 0).
- R2: Type codes (bits 1–3, MSB first) 000, 001, 010 and 011 raise imm_req_o, iso_req_o, pri_req_o and fair_req_o respectively. The strobe is high for exactly the one cycle that follows the clock edge sampling the stop bit.
- R3: A bus request is 8 bits long. Bits 4–6 form a field, MSB first, that appears on bus_field_o with the strobe. Bit 7 is the stop bit.
- R4: Type 100 is a 9-bit register read. Address bits 4–7 (MSB first) appear on reg_addr_o together with a one-cycle rd_req_o pulse. Bit 8 is the stop bit.
- R5: Type 101 is a 17-bit register write. Address bits 4–7 go to reg_addr_o and data bits 8–15 go to wr_data_o, both MSB first, together with a one-cycle wr_req_o pulse. Bit 16 is the stop bit.
- R6: Type codes 110 and 111 are discarded with no strobe and no error. The receiver accepts a new start bit on the edge right after bit 3.
- R7: A high stop bit raises frame_err_o for one cycle. It raises no request strobe and leaves bus_field_o, reg_addr_o and wr_data_o unchanged.
- R8: rst_ni low clears all outputs and returns the receiver to idle, even in the middle of a frame.
- R9: At most one of the seven strobes is high in any cycle. bus_field_o changes only with a bus strobe. reg_addr_o changes only with rd_req_o or wr_req_o. wr_data_o changes only with wr_req_o.
- R10: A start bit on the edge right after a stop bit begins a new frame with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lreq_i | input | 1 | Serial request line from the link layer |
| imm_req_o | output | 1 | Immediate bus request strobe (type 000) |
| iso_req_o | output | 1 | Isochronous bus request strobe (type 001) |
| pri_req_o | output | 1 | Priority bus request strobe (type 010) |
| fair_req_o | output | 1 | Fair bus request strobe (type 011) |
| bus_field_o | output | 3 | Field of the last accepted bus request |
| rd_req_o | output | 1 | Register read strobe |
| wr_req_o | output | 1 | Register write strobe |
| reg_addr_o | output | 4 | Address of the last accepted read or write |
| wr_data_o | output | 8 | Data of the last accepted write |
| frame_err_o | output | 1 | Stop bit was high; the request was dropped |

## Verification
A wrong bit counter or a wrong length decision misframes the request. The strobe then appears one or more cycles off, or under the wrong type. The error pulse can also fire on a valid frame. All of these are visible within the 8 to 17 cycles of the frame being received. A shifter that takes the wrong bit, or fills in the wrong order, shows up as a mirrored or shifted address, data or field value at the very cycle the strobe rises. A receiver that fails to return to idle after a discarded code or a stop bit swallows the start bit of the next frame that follows at once, so the next expected strobe never arrives.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  localparam int unsigned TYPE_W = 3;
  localparam logic [TYPE_W-1:0] CODE_RD = 3'b100;
  localparam logic [TYPE_W-1:0] CODE_WR = 3'b101;

  typedef enum logic [1:0] {K_BUS, K_RD, K_WR} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_TYPE, S_BODY} state_e;
endpackage

// File: rtl/lreq_shreg.sv
module lreq_shreg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (shift_i) q_q <= {q_q[W-2:0], bit_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/lreq_ctrl.sv
module lreq_ctrl
  import lreq_pkg::*;
#(
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lreq_i,
  input  logic [TYPE_W-2:0] type_hist_i,
  output logic              shift_o,
  output logic              fin_o,
  output logic              stop_ok_o,
  output kind_e             kind_o,
  output logic [TYPE_W-1:0] code_o
);
  localparam int unsigned BUS_LAST = TYPE_W + FIELD_W + 1;
  localparam int unsigned RD_LAST  = TYPE_W + ADDR_W + 1;
  localparam int unsigned WR_LAST  = TYPE_W + ADDR_W + DATA_W + 1;
  localparam int unsigned CNT_W    = $clog2(WR_LAST + 1);

  state_e            st_q;
  logic [CNT_W-1:0]  cnt_q, last_q;
  kind_e             kind_q;
  logic [TYPE_W-1:0] code_q;
  logic [TYPE_W-1:0] code_now;

  assign code_now  = {type_hist_i, lreq_i};
  assign fin_o     = (st_q == S_BODY) && (cnt_q == last_q);
  assign stop_ok_o = !lreq_i;
  assign shift_o   = (st_q == S_TYPE) || ((st_q == S_BODY) && (cnt_q != last_q));
  assign kind_o    = kind_q;
  assign code_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      last_q <= '0;
      kind_q <= K_BUS;
      code_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (lreq_i) begin
          st_q  <= S_TYPE;
          cnt_q <= CNT_W'(1);
        end
        S_TYPE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(TYPE_W)) begin
            code_q <= code_now;
            st_q   <= S_BODY;
            // frame length is decided here, on the last type bit
            if (!code_now[TYPE_W-1]) begin
              kind_q <= K_BUS;
              last_q <= CNT_W'(BUS_LAST);
            end else if (code_now == CODE_RD) begin
              kind_q <= K_RD;
              last_q <= CNT_W'(RD_LAST);
            end else if (code_now == CODE_WR) begin
              kind_q <= K_WR;
              last_q <= CNT_W'(WR_LAST);
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        S_BODY: begin
          if (cnt_q == last_q) st_q <= S_IDLE;
          else                 cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lreq_out.sv
module lreq_out
  import lreq_pkg::*;
#(
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NBUS    = 4,
  localparam int unsigned SR_W   = ADDR_W + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fin_i,
  input  logic               stop_ok_i,
  input  kind_e              kind_i,
  input  logic [TYPE_W-1:0]  code_i,
  input  logic [SR_W-1:0]    sr_i,
  output logic [NBUS-1:0]    bus_stb_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               err_o,
  output logic [FIELD_W-1:0] field_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o
);
  logic acc;
  assign acc = fin_i && stop_ok_i;

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bus_stb_o[g] <= 1'b0;
      else         bus_stb_o[g] <= acc && (kind_i == K_BUS) && (code_i == TYPE_W'(g));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      err_o   <= 1'b0;
      field_o <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      rd_o  <= acc && (kind_i == K_RD);
      wr_o  <= acc && (kind_i == K_WR);
      err_o <= fin_i && !stop_ok_i;
      if (acc) begin
        case (kind_i)
          K_BUS: field_o <= sr_i[FIELD_W-1:0];
          K_RD:  addr_o  <= sr_i[ADDR_W-1:0];
          K_WR: begin
            addr_o <= sr_i[DATA_W +: ADDR_W];
            data_o <= sr_i[DATA_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lreq_rx.sv
module lreq_rx
  import lreq_pkg::*;
#(
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lreq_i,
  output logic               imm_req_o,
  output logic               iso_req_o,
  output logic               pri_req_o,
  output logic               fair_req_o,
  output logic [FIELD_W-1:0] bus_field_o,
  output logic               rd_req_o,
  output logic               wr_req_o,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               frame_err_o
);
  localparam int unsigned SR_W = ADDR_W + DATA_W;
  localparam int unsigned NBUS = 4;

  logic              shift, fin, stop_ok;
  kind_e             kind;
  logic [TYPE_W-1:0] code;
  logic [SR_W-1:0]   sr;
  logic [NBUS-1:0]   bus_stb;

  lreq_shreg #(.W(SR_W)) u_shreg (
    .clk_i, .rst_ni, .shift_i(shift), .bit_i(lreq_i), .q_o(sr)
  );

  lreq_ctrl #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .lreq_i,
    .type_hist_i(sr[TYPE_W-2:0]),
    .shift_o(shift), .fin_o(fin), .stop_ok_o(stop_ok),
    .kind_o(kind), .code_o(code)
  );

  lreq_out #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBUS(NBUS)) u_out (
    .clk_i, .rst_ni, .fin_i(fin), .stop_ok_i(stop_ok),
    .kind_i(kind), .code_i(code), .sr_i(sr),
    .bus_stb_o(bus_stb), .rd_o(rd_req_o), .wr_o(wr_req_o), .err_o(frame_err_o),
    .field_o(bus_field_o), .addr_o(reg_addr_o), .data_o(wr_data_o)
  );

  assign imm_req_o  = bus_stb[0];
  assign iso_req_o  = bus_stb[1];
  assign pri_req_o  = bus_stb[2];
  assign fair_req_o = bus_stb[3];
endmodule

// File: rtl/lreq_rx_chk.sv
module lreq_rx_chk #(
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lreq_i,
  input logic               imm_req_o,
  input logic               iso_req_o,
  input logic               pri_req_o,
  input logic               fair_req_o,
  input logic [FIELD_W-1:0] bus_field_o,
  input logic               rd_req_o,
  input logic               wr_req_o,
  input logic [ADDR_W-1:0]  reg_addr_o,
  input logic [DATA_W-1:0]  wr_data_o,
  input logic               frame_err_o
);
  logic [6:0] stb;
  logic       bus_any, req_any;
  assign stb     = {imm_req_o, iso_req_o, pri_req_o, fair_req_o, rd_req_o, wr_req_o, frame_err_o};
  assign bus_any = imm_req_o | iso_req_o | pri_req_o | fair_req_o;
  assign req_any = bus_any | rd_req_o | wr_req_o;

  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(stb));
  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (|stb) |=> !(|stb));
  // R3
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) req_any |-> !$past(lreq_i));
  // R7
  err_stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) frame_err_o |-> $past(lreq_i));
  // R9
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(bus_field_o) |-> bus_any);
  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(reg_addr_o) |-> (rd_req_o | wr_req_o));
  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(wr_data_o) |-> wr_req_o);
endmodule

bind lreq_rx lreq_rx_chk #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lreq_rx_test.sv
module lreq_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lreq = 1'b0;
  logic       imm, iso, pri, fair, rd, wr, err;
  logic [2:0] fld;
  logic [3:0] addr;
  logic [7:0] data;
  int         n_chk = 0;
  int         n_fail = 0;

  localparam logic [6:0] ST_IMM = 7'b1000000, ST_RD = 7'b0000100,
                         ST_WR = 7'b0000010, ST_ERR = 7'b0000001;

  always #10 clk = ~clk;

  lreq_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .lreq_i(lreq),
    .imm_req_o(imm), .iso_req_o(iso), .pri_req_o(pri), .fair_req_o(fair),
    .bus_field_o(fld), .rd_req_o(rd), .wr_req_o(wr),
    .reg_addr_o(addr), .wr_data_o(data), .frame_err_o(err)
  );

  function automatic logic [6:0] stb();
    return {imm, iso, pri, fair, rd, wr, err};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // frame vector: bit n-1 is the start bit, sent first
  task automatic send(input logic [16:0] f, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); lreq = f[i];
    end
    @(negedge clk); lreq = 1'b0;
  endtask

  function automatic logic [16:0] bus_f(input logic [2:0] t, input logic [2:0] v);
    return {9'b0, 1'b1, t, v, 1'b0};
  endfunction
  function automatic logic [16:0] rd_f(input logic [3:0] a, input logic stop);
    return {8'b0, 1'b1, 3'b100, a, stop};
  endfunction
  function automatic logic [16:0] wr_f(input logic [3:0] a, input logic [7:0] d);
    return {1'b1, 3'b101, a, d, 1'b0};
  endfunction

  task automatic t_reset();
    chk("R8 strobes in reset", 32'(stb()), 0);
    chk("R8 fields in reset", {fld, addr, data}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_idle();
    logic [6:0] acc = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); acc |= stb();
    end
    chk("R1 idle line quiet", 32'(acc), 0);
  endtask

  task automatic t_bus();
    for (int t = 0; t < 4; t++) begin
      send(bus_f(3'(t), 3'(t) ^ 3'b110), 8);
      chk("R2 bus strobe", 32'(stb()), 32'(ST_IMM >> t));
      chk("R3 bus field", 32'(fld), 32'(3'(t) ^ 3'b110));
      @(negedge clk);
      chk("R2 strobe one cycle", 32'(stb()), 0);
    end
  endtask

  task automatic t_read();
    send(rd_f(4'hA, 1'b0), 9);
    chk("R4 read strobe", 32'(stb()), 32'(ST_RD));
    chk("R4 read addr", 32'(addr), 32'hA);
  endtask

  task automatic t_write();
    send(wr_f(4'h5, 8'hC3), 17);
    chk("R5 write strobe", 32'(stb()), 32'(ST_WR));
    chk("R5 write addr/data", {addr, data}, 32'h5C3);
    @(negedge clk);
    chk("R9 fields held", {stb(), addr, data}, 32'h5C3);
    send(wr_f(4'h1, 8'h3C), 17);
    chk("R5 write msb first", {addr, data}, 32'h13C);
  endtask

  task automatic t_err();
    send(rd_f(4'h3, 1'b1), 9);
    chk("R7 error strobe", 32'(stb()), 32'(ST_ERR));
    chk("R7 addr unchanged", 32'(addr), 32'h1);
    send({9'b0, 1'b1, 3'b011, 3'b001, 1'b1}, 8);
    chk("R7 bus error", {stb(), 1'b0, fld}, {ST_ERR, 1'b0, 3'b011 ^ 3'b110});
  endtask

  task automatic t_bad();
    logic [6:0] acc = '0;
    send({13'b0, 4'b1110}, 4);
    for (int i = 0; i < 12; i++) begin
      acc |= stb(); @(negedge clk);
    end
    chk("R6 code 110 dropped", 32'(acc), 0);
    // code 111 then a priority request whose start bit follows bit 3 at once
    send({5'b0, 4'b1111, 1'b1, 3'b010, 3'b100, 1'b0}, 12);
    chk("R6 restart after bad code", {stb(), 1'b0, fld}, {7'b0010000, 1'b0, 3'b100});
  endtask

  task automatic t_b2b();
    logic [16:0] f1 = wr_f(4'h9, 8'h66);
    logic [16:0] f2 = rd_f(4'h6, 1'b0);
    for (int i = 16; i >= 0; i--) begin
      @(negedge clk); lreq = f1[i];
    end
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk); lreq = f2[i];
      if (i == 8) chk("R10 first frame strobe", {stb(), addr, data}, {ST_WR, 4'h9, 8'h66});
    end
    @(negedge clk); lreq = 1'b0;
    chk("R10 second frame strobe", {stb(), addr}, {ST_RD, 4'h6});
  endtask

  task automatic t_reset_mid();
    logic [16:0] f = wr_f(4'hF, 8'hFF);
    for (int i = 16; i >= 12; i--) begin
      @(negedge clk); lreq = f[i];
    end
    rst_n = 1'b0; lreq = 1'b0;
    @(negedge clk);
    chk("R8 reset mid frame", {stb(), addr, data}, 0);
    rst_n = 1'b1;
    send(bus_f(3'b000, 3'b010), 8);
    chk("R8 clean after reset", {stb(), 1'b0, fld}, {ST_IMM, 1'b0, 3'b010});
  endtask

  initial begin
    #45;
    t_reset();
    t_idle();
    t_bus();
    t_read();
    t_write();
    t_err();
    t_bad();
    t_b2b();
    t_reset_mid();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule